// File: doc/BRIEF.md
# Misaligned Vector Load Funnel

The block builds 512-bit vectors that start at any byte address, using only aligned 64-byte line reads. A small file of four alignment entries holds the most recent line of each stream. An aligning load joins the held line with a newly fetched line and cuts a 512-bit window out of the pair, moving in whole 32-bit words. It then stores the new line back into the same entry, so the next load of the stream continues from where this one ended.

Software-visible behaviour is driven by a command port with four operations: clear an entry, prime an entry from a line, run an aligning load, and load the base pointer. Every prime and every aligning load post-increments the base pointer, either by one line or by the command's argument. Line reads go out through a single-outstanding request port. Assembled vectors leave on a result port with a one-cycle valid pulse.

Top module: `misalign_ld_funnel`

## Requirements
- R1: After reset, cmd_ready_o is 1, rd_req_o is 0 and res_valid_o is 0.
- R2: The entry is selected by cmd_idx_i[1:0]; the upper bits of cmd_idx_i have no effect.
- R3: Clear (cmd_op_i = 0) sets the selected entry to zero, issues no line read and produces no result.
- R4: Prime (cmd_op_i = 1) reads the line at the base pointer with bits [5:0] forced to zero, stores the returned line in the selected entry and produces no result.
- R5: Aligning load (cmd_op_i = 2) reads the line at the aligned base pointer. With s = base[5:2], pool words 0..15 = held entry words 0..15 and pool words 16..31 = fetched line words 0..15 (word w = bits 32w+31:32w), output word k is pool word s+k. Base bits [1:0] do not affect the window.
- R6: An aligning load writes the fetched line into the entry it read.
- R7: Prime and aligning load post-increment the base pointer by 64 when cmd_step_sel_i = 0 and by cmd_arg_i when it is 1; set-base (cmd_op_i = 3) loads cmd_arg_i into the base pointer; clear leaves it unchanged.
- R8: At most one line read is outstanding; cmd_ready_o is low while a read is pending, except in the cycle its data returns.
- R9: A command accepted in the cycle a line returns sees that line in the entry (forwarding). The entry is updated at the edge ending the return cycle, and res_valid_o rises one cycle after that.
- R10: While rd_req_o is high, rd_addr_o has bits [5:0] at zero and holds steady until rd_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted this cycle when valid |
| cmd_op_i | input | 2 | 0 clear, 1 prime, 2 aligning load, 3 set base |
| cmd_idx_i | input | 4 | Entry index field, low 2 bits used |
| cmd_step_sel_i | input | 1 | 0 step by one line, 1 step by cmd_arg_i |
| cmd_arg_i | input | 32 | Step amount or new base pointer |
| rd_req_o | output | 1 | Line read pending |
| rd_addr_o | output | 32 | Aligned line address |
| rd_valid_i | input | 1 | Line data returned |
| rd_data_i | input | 512 | Returned line |
| res_valid_o | output | 1 | Assembled vector valid |
| res_data_o | output | 512 | Assembled vector |

## Verification
On every cycle the assertions check the read-port protocol: ready drops only while a read is pending, addresses are line-aligned and held steady, a clear never starts a read, and each result follows a line return by exactly two cycles. Window contents, the carry of a line from one load to the next, forwarding when commands come back to back, entry isolation and base arithmetic depend on data. Only the bench's sweeps over every word shift, byte phase, response delay and step mode can show them.

// File: rtl/mlf_pkg.sv
package mlf_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_PRIME = 2'd1,
    OP_LOAD  = 2'd2,
    OP_BASE  = 2'd3
  } mlf_op_e;
endpackage

// File: rtl/mlf_entry_file.sv
module mlf_entry_file #(
  parameter int LINE_W = 512,
  parameter int N_ENT  = 4,
  localparam int SEL_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [LINE_W-1:0] wr_data_i,
  input  logic              clr_en_i,
  input  logic [SEL_W-1:0]  clr_sel_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [LINE_W-1:0] rd_data_o
);
  logic [LINE_W-1:0] ent_q [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= '0;
      end else if (clr_en_i && clr_sel_i == SEL_W'(g)) begin
        // clear is younger than any returning line
        ent_q[g] <= '0;
      end else if (wr_en_i && wr_sel_i == SEL_W'(g)) begin
        ent_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = ent_q[rd_sel_i];
endmodule

// File: rtl/mlf_funnel.sv
module mlf_funnel #(
  parameter int LINE_W = 512,
  parameter int WORD_W = 32,
  localparam int N_W   = LINE_W / WORD_W,
  localparam int SH_W  = $clog2(N_W)
) (
  input  logic [LINE_W-1:0] carried_i,
  input  logic [LINE_W-1:0] fresh_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic [LINE_W-1:0] win_o
);
  logic [WORD_W-1:0] pool_w [2*N_W];

  for (genvar j = 0; j < N_W; j++) begin : g_pool
    assign pool_w[j]       = carried_i[j*WORD_W +: WORD_W];
    assign pool_w[j + N_W] = fresh_i[j*WORD_W +: WORD_W];
  end

  for (genvar k = 0; k < N_W; k++) begin : g_win
    assign win_o[k*WORD_W +: WORD_W] = pool_w[k + int'(shift_i)];
  end
endmodule

// File: rtl/mlf_ctrl.sv
module mlf_ctrl
  import mlf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 512,
  parameter int WORD_W = 32,
  parameter int N_ENT  = 4,
  localparam int SEL_W = $clog2(N_ENT),
  localparam int LINE_B = LINE_W / 8,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int WB_W  = $clog2(WORD_W / 8),
  localparam int SH_W  = OFF_W - WB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  mlf_op_e           cmd_op_i,
  input  logic [SEL_W-1:0]  cmd_sel_i,
  input  logic              cmd_step_sel_i,
  input  logic [ADDR_W-1:0] cmd_arg_i,
  input  logic              rd_valid_i,
  output logic              cmd_ready_o,
  output logic              accept_o,
  output logic              resp_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output mlf_op_e           pend_op_o,
  output logic [SEL_W-1:0]  pend_sel_o,
  output logic [SH_W-1:0]   pend_shift_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] base_q, addr_q, step;
  mlf_op_e           op_q;
  logic [SEL_W-1:0]  sel_q;
  logic [SH_W-1:0]   shift_q;
  logic              reads;

  assign cmd_ready_o = !pend_q || rd_valid_i;
  assign accept_o    = cmd_valid_i && cmd_ready_o;
  assign resp_o      = pend_q && rd_valid_i;
  assign reads       = (cmd_op_i == OP_PRIME) || (cmd_op_i == OP_LOAD);
  assign step        = cmd_step_sel_i ? cmd_arg_i : ADDR_W'(LINE_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      addr_q  <= '0;
      op_q    <= OP_CLEAR;
      sel_q   <= '0;
      shift_q <= '0;
    end else if (accept_o && reads) begin
      pend_q  <= 1'b1;
      addr_q  <= {base_q[ADDR_W-1:OFF_W], OFF_W'(0)};
      op_q    <= cmd_op_i;
      sel_q   <= cmd_sel_i;
      shift_q <= base_q[OFF_W-1:WB_W];
    end else if (resp_o) begin
      pend_q  <= 1'b0;
    end
  end

  // post-increment at issue keeps later commands free of base forwarding
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (accept_o) begin
      if (cmd_op_i == OP_BASE) base_q <= cmd_arg_i;
      else if (reads)          base_q <= base_q + step;
    end
  end

  assign rd_req_o     = pend_q;
  assign rd_addr_o    = pend_q ? addr_q : '0;
  assign pend_op_o    = op_q;
  assign pend_sel_o   = sel_q;
  assign pend_shift_o = shift_q;
endmodule

// File: rtl/misalign_ld_funnel.sv
module misalign_ld_funnel
  import mlf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 512,
  parameter int WORD_W = 32,
  parameter int N_ENT  = 4,
  parameter int IDX_W  = 4,
  localparam int SEL_W = $clog2(N_ENT),
  localparam int SH_W  = $clog2(LINE_W / WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic              cmd_step_sel_i,
  input  logic [ADDR_W-1:0] cmd_arg_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [LINE_W-1:0] rd_data_i,
  output logic              res_valid_o,
  output logic [LINE_W-1:0] res_data_o
);
  mlf_op_e           op, pend_op;
  logic [SEL_W-1:0]  sel, pend_sel;
  logic [SH_W-1:0]   pend_shift;
  logic              accept, resp;
  logic [LINE_W-1:0] file_rd, carried_fwd, carried_q;
  logic              s1_valid_q;
  logic [LINE_W-1:0] s1_carried_q, s1_fresh_q, win;
  logic [SH_W-1:0]   s1_shift_q;
  logic              unused_idx;

  assign op         = mlf_op_e'(cmd_op_i);
  assign sel        = cmd_idx_i[SEL_W-1:0];
  assign unused_idx = ^cmd_idx_i[IDX_W-1:SEL_W];

  mlf_ctrl #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .WORD_W(WORD_W), .N_ENT(N_ENT)
  ) ctrl_i (
    .clk_i, .rst_ni,
    .cmd_valid_i,
    .cmd_op_i      (op),
    .cmd_sel_i     (sel),
    .cmd_step_sel_i,
    .cmd_arg_i,
    .rd_valid_i,
    .cmd_ready_o,
    .accept_o      (accept),
    .resp_o        (resp),
    .rd_req_o,
    .rd_addr_o,
    .pend_op_o     (pend_op),
    .pend_sel_o    (pend_sel),
    .pend_shift_o  (pend_shift)
  );

  mlf_entry_file #(.LINE_W(LINE_W), .N_ENT(N_ENT)) file_i (
    .clk_i, .rst_ni,
    .wr_en_i   (resp),
    .wr_sel_i  (pend_sel),
    .wr_data_i (rd_data_i),
    .clr_en_i  (accept && op == OP_CLEAR),
    .clr_sel_i (sel),
    .rd_sel_i  (sel),
    .rd_data_o (file_rd)
  );

  // line landing this cycle is newer than the file copy
  assign carried_fwd = (resp && pend_sel == sel) ? rd_data_i : file_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        carried_q <= '0;
    else if (accept && op == OP_LOAD)   carried_q <= carried_fwd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q   <= 1'b0;
      s1_carried_q <= '0;
      s1_fresh_q   <= '0;
      s1_shift_q   <= '0;
    end else begin
      s1_valid_q <= resp && pend_op == OP_LOAD;
      if (resp && pend_op == OP_LOAD) begin
        s1_carried_q <= carried_q;
        s1_fresh_q   <= rd_data_i;
        s1_shift_q   <= pend_shift;
      end
    end
  end

  mlf_funnel #(.LINE_W(LINE_W), .WORD_W(WORD_W)) funnel_i (
    .carried_i (s1_carried_q),
    .fresh_i   (s1_fresh_q),
    .shift_i   (s1_shift_q),
    .win_o     (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
    end else begin
      res_valid_o <= s1_valid_q;
      if (s1_valid_q) res_data_o <= win;
    end
  end
endmodule

// File: rtl/mlf_chk.sv
module mlf_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic [1:0]        cmd_op_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic              res_valid_o
);
  // R8
  ready_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ready_o |-> rd_req_o);

  // R10
  aligned_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[5:0] == 6'd0);

  // R10
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));

  // R3
  clear_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && cmd_op_i == 2'd0 |=> !rd_req_o);

  // R9
  res_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(rd_valid_i && rd_req_o, 2));
endmodule

bind misalign_ld_funnel mlf_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_op_i    (cmd_op_i),
  .rd_req_o    (rd_req_o),
  .rd_addr_o   (rd_addr_o),
  .rd_valid_i  (rd_valid_i),
  .res_valid_o (res_valid_o)
);

// File: tb/misalign_ld_funnel_tb_top.sv
module misalign_ld_funnel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [3:0]    cmd_idx = 4'd0;
  logic          cmd_step_sel = 1'b0;
  logic [31:0]   cmd_arg = '0;
  logic          rd_req;
  logic [31:0]   rd_addr;
  logic          rd_valid = 1'b0;
  logic [LW-1:0] rd_data = '0;
  logic          res_valid;
  logic [LW-1:0] res_data;

  int n_chk = 0, n_fail = 0;
  int mem_dly = 0, dly_cnt = 0;
  int reads_seen = 0;

  logic [LW-1:0] sh_ent [4];
  logic [31:0]   sh_base = '0;
  logic [LW-1:0] exp_q [2048];
  int            exp_wr = 0, exp_rd = 0;
  logic [31:0]   addr_q [4096];
  int            addr_wr = 0, addr_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  misalign_ld_funnel dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_idx_i(cmd_idx),
    .cmd_step_sel_i(cmd_step_sel), .cmd_arg_i(cmd_arg),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .res_valid_o(res_valid), .res_data_o(res_data)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a, int w);
    return ((a >> 6) * 32'h9E3779B1) ^ (32'(w + 1) * 32'h01000193) ^ 32'hA5C30000;
  endfunction

  function automatic logic [LW-1:0] mem_line(logic [31:0] a);
    logic [LW-1:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = mem_word(a, w);
    return l;
  endfunction

  function automatic logic [LW-1:0] exp_win(logic [LW-1:0] c, logic [LW-1:0] f, int s);
    logic [LW-1:0] r;
    for (int k = 0; k < 16; k++) begin
      int j = s + k;
      r[k*32 +: 32] = (j < 16) ? c[j*32 +: 32] : f[(j-16)*32 +: 32];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one response per request after mem_dly idle cycles
  always @(negedge clk) begin
    bit prev;
    prev = rd_valid;
    rd_valid = 1'b0;
    if (rst_n && rd_req) begin
      if (prev) dly_cnt = 0;
      if (dly_cnt >= mem_dly) begin
        // R4 R7 R10: aligned address follows the base pointer sequence
        check(rd_addr == addr_q[addr_rd], "R7", LW'(rd_addr), LW'(addr_q[addr_rd]));
        addr_rd++;
        reads_seen++;
        rd_data  = mem_line(rd_addr);
        rd_valid = 1'b1;
        dly_cnt  = 0;
      end else begin
        dly_cnt++;
      end
    end
  end

  // R5 R6 R9: results in command order
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      check(exp_rd < exp_wr && res_data == exp_q[exp_rd], "R5", res_data, exp_q[exp_rd]);
      exp_rd++;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [3:0] idx, input logic ssel, input logic [31:0] arg);
    int e = int'(idx[1:0]);
    logic [31:0] al = {sh_base[31:6], 6'd0};
    logic [31:0] stp = ssel ? arg : 32'd64;
    case (op)
      2'd0: sh_ent[e] = '0;
      2'd1: begin
        addr_q[addr_wr] = al; addr_wr++;
        sh_ent[e] = mem_line(al);
        sh_base = sh_base + stp;
      end
      2'd2: begin
        addr_q[addr_wr] = al; addr_wr++;
        exp_q[exp_wr] = exp_win(sh_ent[e], mem_line(al), int'(sh_base[5:2])); exp_wr++;
        sh_ent[e] = mem_line(al);
        sh_base = sh_base + stp;
      end
      default: sh_base = arg;
    endcase
    @(negedge clk);
    cmd_op = op; cmd_idx = idx; cmd_step_sel = ssel; cmd_arg = arg;
    cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) sh_ent[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    check(cmd_ready == 1'b1, "R1", LW'(cmd_ready), LW'(1));
    check(rd_req == 1'b0, "R1", LW'(rd_req), LW'(0));
    check(res_valid == 1'b0, "R1", LW'(res_valid), LW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && rd_req == 1'b0, "R1", LW'({cmd_ready, rd_req}), LW'(2));

    // sweep every word shift and byte phase under three response delays
    for (int d = 0; d < 3; d++) begin
      mem_dly = d;
      for (int s = 0; s < 16; s++) begin
        for (int b = 0; b < 4; b++) begin
          logic [3:0] idx = 4'((s % 4) + 4 * b); // R2: upper index bits vary
          issue(2'd3, 4'd0, 1'b0, 32'h2000 + 32'(d * 'h800 + s * 'h40 + s * 4 + b));
          issue(2'd1, idx, 1'b0, 32'd0);
          issue(2'd2, idx, 1'b0, 32'd0);
          issue(2'd2, idx ^ 4'hC, 1'b0, 32'd0); // R9: back-to-back same entry
        end
      end
    end

    // R7: register step moves the word phase on each load
    for (int d = 0; d < 2; d++) begin
      mem_dly = d;
      issue(2'd3, 4'd0, 1'b0, 32'h8007);
      issue(2'd1, 4'd2, 1'b1, 32'd20);
      for (int k = 0; k < 24; k++) issue(2'd2, 4'd2, 1'b1, 32'(4 * k + 1));
    end

    // R3: cleared entry feeds zeros into the low pool words
    mem_dly = 1;
    for (int s = 0; s < 16; s++) begin
      issue(2'd3, 4'd0, 1'b0, 32'h9000 + 32'(s * 4));
      issue(2'd1, 4'd1, 1'b0, 32'd0);
      issue(2'd0, 4'd5, 1'b0, 32'd0);
      issue(2'd2, 4'd1, 1'b0, 32'd0);
    end

    // R2 R6: four streams primed apart, loaded in reverse order
    mem_dly = 0;
    for (int e = 0; e < 4; e++) begin
      issue(2'd3, 4'd0, 1'b0, 32'hA000 + 32'(e * 'h1000 + e * 12));
      issue(2'd1, 4'(e + 8), 1'b0, 32'd0);
    end
    for (int e = 3; e >= 0; e--) begin
      issue(2'd3, 4'd0, 1'b0, 32'hA040 + 32'(e * 'h1000 + e * 12));
      issue(2'd2, 4'(e), 1'b0, 32'd0);
      issue(2'd2, 4'(e + 4), 1'b0, 32'd0);
    end

    repeat (20) @(negedge clk);
    // R4: primes and clears yield no results; R3: clears issue no reads
    check(exp_rd == exp_wr, "R4", LW'(exp_rd), LW'(exp_wr));
    check(reads_seen == addr_wr, "R3", LW'(reads_seen), LW'(addr_wr));
    check(rd_req == 1'b0 && cmd_ready == 1'b1, "R8", LW'({rd_req, cmd_ready}), LW'(1));
    finish_run();
  end
endmodule